// File: doc/BRIEF.md
# Hardware Boot Sequencer

This block runs a processor boot without any software help. When the start input is seen, it holds the processor in reset and takes the memory bus for itself. It then asks an external storage reader for block 0 and checks the partition signature in that block. From the same block it takes the start of the first partition. Next it reads the file system superblock at that address. There it checks the magic number and picks up the root directory handle.

After these two checks, it starts an external lookup engine and then an external copy engine, one at a time. Each engine has a one-cycle start pulse and finish and error inputs. A five-bit status register shows which stage failed, or that the boot completed. This register can drive indicator lights directly.

Block data comes in as a byte stream with a valid/ready handshake. The sequencer raises ready only while it is reading a block. It accepts exactly one block of bytes per request. The reader may hold valid low between bytes for any number of cycles. Each block request is a separate valid/ready handshake. The request address stays stable until the request is accepted.

Top module: `boot_seq_top`

## Requirements
- R1: After reset the processor hold is low, the bus is not owned, no request is pending and the status reads 0.
- R2: On start from idle, the processor hold and bus ownership go high, and the first request asks for block 0.
- R3: Each request is held with a stable address until it is accepted. The sequencer then accepts exactly BLOCK_BYTES data bytes and tolerates stalls on the data valid.
- R4: The partition table passes only if byte 0x1FE of block 0 is 0x55 and byte 0x1FF is 0xAA. Otherwise status bit 0 is set and the boot stops.
- R5: The partition start is the little-endian 32-bit value at bytes 0x1C6..0x1C9 of block 0. It appears on part_base, and the superblock request uses it as the block address.
- R6: The superblock passes only if its bytes 0..1, read little-endian, equal 0x614E. Otherwise status bit 1 is set and the boot stops.
- R7: The root handle is the little-endian 32-bit value at superblock bytes 4..7. It is presented on lkp_root when the one-cycle lookup start pulse is issued.
- R8: Lookup starts only after the superblock passes. A lookup error sets status bit 2 and stops the boot. Copy starts only after lookup finishes.
- R9: A copy error sets status bit 3. A copy finish sets status bit 4 (done) and releases both the processor hold and the bus.
- R10: After any stage error, the processor hold stays high, the bus is released, and start is ignored until reset.
- R11: A start during a boot is ignored. A start after done clears the status and runs the whole boot again.
- R12: At most one status bit is set at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| boot_start | input | 1 | Begin a boot |
| rd_req_valid | output | 1 | Block read request valid |
| rd_req_ready | input | 1 | Reader accepts the request |
| rd_req_lba | output | 32 | Block address of the request |
| rd_data_valid | input | 1 | Data byte valid |
| rd_data_ready | output | 1 | Sequencer accepts a data byte |
| rd_data | input | 8 | Data byte |
| lkp_start | output | 1 | One-cycle lookup start pulse |
| lkp_root | output | 32 | Root directory handle for lookup |
| lkp_done | input | 1 | Lookup finished |
| lkp_err | input | 1 | Lookup failed |
| cpy_start | output | 1 | One-cycle copy start pulse |
| cpy_done | input | 1 | Copy finished |
| cpy_err | input | 1 | Copy failed |
| part_base | output | 32 | Captured first partition start block |
| cpu_rst_hold | output | 1 | Hold the processor in reset |
| bus_own | output | 1 | Sequencer owns the memory bus |
| status | output | 5 | [0] partition, [1] file system, [2] lookup, [3] copy failed, [4] done |

## Verification
If the byte counter were off by one, the fields would be captured from the wrong offsets. The result would be a wrong signature or magic verdict, or a wrong part_base or superblock address, and it would show as soon as the block that carries the field finishes. If the state register got stuck, a missing or repeated request or start pulse would show. The request count and engine start count at the end of each run reveal this. A status or gating fault shows in the next cycle, because the status bits, cpu_rst_hold and bus_own must agree with one another at all times.

// File: rtl/boot_seq_pkg.sv
package boot_seq_pkg;
  localparam int SIG_OFF    = 'h1FE;
  localparam int PART_OFF   = 'h1C6;
  localparam int MAGIC_OFF  = 0;
  localparam int ROOT_OFF   = 4;
  localparam logic [15:0] SIG_VAL   = 16'hAA55;
  localparam logic [15:0] MAGIC_VAL = 16'h614E;
  localparam int NSTAGE = 4;

  typedef enum logic [3:0] {
    ST_IDLE, ST_MBR_REQ, ST_MBR_RD, ST_SB_REQ, ST_SB_RD,
    ST_LKP_GO, ST_LKP_WAIT, ST_CPY_GO, ST_CPY_WAIT, ST_DONE, ST_FAIL
  } boot_state_e;
endpackage

// File: rtl/block_field_grab.sv
module block_field_grab
  import boot_seq_pkg::*;
#(
  parameter int BLOCK_BYTES = 512,
  localparam int IDXW = $clog2(BLOCK_BYTES)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        arm,
  input  logic        beat,
  input  logic        sel_sb,
  input  logic [7:0]  byte_in,
  output logic        full,
  output logic [15:0] half16,
  output logic [31:0] word32
);
  logic [IDXW-1:0] idx;
  logic [IDXW-1:0] half_off, word_off;

  assign half_off = sel_sb ? IDXW'(MAGIC_OFF) : IDXW'(SIG_OFF);
  assign word_off = sel_sb ? IDXW'(ROOT_OFF)  : IDXW'(PART_OFF);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx    <= '0;
      full   <= 1'b0;
      half16 <= '0;
      word32 <= '0;
    end else if (arm) begin
      idx  <= '0;
      full <= 1'b0;
    end else if (beat && !full) begin
      if (idx == half_off)            half16[7:0]  <= byte_in;
      if (idx == half_off + IDXW'(1)) half16[15:8] <= byte_in;
      for (int k = 0; k < 4; k++) begin
        if (idx == word_off + IDXW'(k)) word32[8*k +: 8] <= byte_in;
      end
      if (idx == IDXW'(BLOCK_BYTES - 1)) begin
        idx  <= '0;
        full <= 1'b1;
      end else begin
        idx <= idx + IDXW'(1);
      end
    end
  end
endmodule

// File: rtl/boot_status.sv
module boot_status
  import boot_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic [NSTAGE-1:0] err_set,
  input  logic              done_set,
  output logic [NSTAGE:0]   status
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          status <= '0;
    else if (clr)        status <= '0;
    else if (|err_set)   status <= {1'b0, err_set};
    else if (done_set)   status[NSTAGE] <= 1'b1;
  end
endmodule

// File: rtl/boot_stage_ctrl.sv
module boot_stage_ctrl
  import boot_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              req_ready,
  input  logic              full,
  input  logic [15:0]       half16,
  input  logic [31:0]       word32,
  input  logic              lkp_done,
  input  logic              lkp_err,
  input  logic              cpy_done,
  input  logic              cpy_err,
  output logic              req_valid,
  output logic [31:0]       req_lba,
  output logic              arm,
  output logic              data_ready,
  output logic              sel_sb,
  output logic              lkp_start,
  output logic              cpy_start,
  output logic [31:0]       part_q,
  output logic [31:0]       root_q,
  output logic              hold,
  output logic              bus,
  output logic [NSTAGE-1:0] err_set,
  output logic              done_set,
  output logic              clr
);
  boot_state_e st, nx;
  logic mbr_end, sb_end, sig_ok, magic_ok;

  assign mbr_end  = (st == ST_MBR_RD) && full;
  assign sb_end   = (st == ST_SB_RD) && full;
  assign sig_ok   = (half16 == SIG_VAL);
  assign magic_ok = (half16 == MAGIC_VAL);

  always_comb begin
    nx = st;
    unique case (st)
      ST_IDLE, ST_DONE: if (start) nx = ST_MBR_REQ;
      ST_MBR_REQ:  if (req_ready) nx = ST_MBR_RD;
      ST_MBR_RD:   if (full) nx = sig_ok ? ST_SB_REQ : ST_FAIL;
      ST_SB_REQ:   if (req_ready) nx = ST_SB_RD;
      ST_SB_RD:    if (full) nx = magic_ok ? ST_LKP_GO : ST_FAIL;
      ST_LKP_GO:   nx = ST_LKP_WAIT;
      ST_LKP_WAIT: if (lkp_err) nx = ST_FAIL; else if (lkp_done) nx = ST_CPY_GO;
      ST_CPY_GO:   nx = ST_CPY_WAIT;
      ST_CPY_WAIT: if (cpy_err) nx = ST_FAIL; else if (cpy_done) nx = ST_DONE;
      default:     nx = st;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      part_q <= '0;
      root_q <= '0;
    end else begin
      st <= nx;
      if (mbr_end && sig_ok)  part_q <= word32;
      if (sb_end && magic_ok) root_q <= word32;
    end
  end

  assign req_valid  = (st == ST_MBR_REQ) || (st == ST_SB_REQ);
  assign req_lba    = (st == ST_SB_REQ) ? part_q : 32'd0;
  assign arm        = req_valid && req_ready;
  assign data_ready = ((st == ST_MBR_RD) || (st == ST_SB_RD)) && !full;
  assign sel_sb     = (st == ST_SB_REQ) || (st == ST_SB_RD);
  assign lkp_start  = (st == ST_LKP_GO);
  assign cpy_start  = (st == ST_CPY_GO);
  assign hold       = (st != ST_IDLE) && (st != ST_DONE);
  assign bus        = hold && (st != ST_FAIL);
  assign clr        = ((st == ST_IDLE) || (st == ST_DONE)) && start;
  assign err_set    = {(st == ST_CPY_WAIT) && cpy_err,
                       (st == ST_LKP_WAIT) && lkp_err,
                       sb_end && !magic_ok,
                       mbr_end && !sig_ok};
  assign done_set   = (st == ST_CPY_WAIT) && cpy_done && !cpy_err;
endmodule

// File: rtl/boot_seq_top.sv
module boot_seq_top
  import boot_seq_pkg::*;
#(
  parameter int BLOCK_BYTES = 512
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          boot_start,
  output logic          rd_req_valid,
  input  logic          rd_req_ready,
  output logic [31:0]   rd_req_lba,
  input  logic          rd_data_valid,
  output logic          rd_data_ready,
  input  logic [7:0]    rd_data,
  output logic          lkp_start,
  output logic [31:0]   lkp_root,
  input  logic          lkp_done,
  input  logic          lkp_err,
  output logic          cpy_start,
  input  logic          cpy_done,
  input  logic          cpy_err,
  output logic [31:0]   part_base,
  output logic          cpu_rst_hold,
  output logic          bus_own,
  output logic [NSTAGE:0] status
);
  logic arm, full, sel_sb, done_set, clr;
  logic [15:0] half16;
  logic [31:0] word32;
  logic [NSTAGE-1:0] err_set;

  block_field_grab #(.BLOCK_BYTES(BLOCK_BYTES)) u_grab (
    .clk(clk), .rst_n(rst_n), .arm(arm),
    .beat(rd_data_valid && rd_data_ready), .sel_sb(sel_sb),
    .byte_in(rd_data), .full(full), .half16(half16), .word32(word32));

  boot_stage_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(boot_start), .req_ready(rd_req_ready),
    .full(full), .half16(half16), .word32(word32),
    .lkp_done(lkp_done), .lkp_err(lkp_err), .cpy_done(cpy_done), .cpy_err(cpy_err),
    .req_valid(rd_req_valid), .req_lba(rd_req_lba), .arm(arm),
    .data_ready(rd_data_ready), .sel_sb(sel_sb),
    .lkp_start(lkp_start), .cpy_start(cpy_start),
    .part_q(part_base), .root_q(lkp_root),
    .hold(cpu_rst_hold), .bus(bus_own),
    .err_set(err_set), .done_set(done_set), .clr(clr));

  boot_status u_status (
    .clk(clk), .rst_n(rst_n), .clr(clr), .err_set(err_set),
    .done_set(done_set), .status(status));
endmodule

// File: rtl/boot_seq_checker.sv
module boot_seq_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        cpu_rst_hold,
  input logic        bus_own,
  input logic [4:0]  status,
  input logic        lkp_start,
  input logic        cpy_start,
  input logic        rd_req_valid,
  input logic        rd_req_ready,
  input logic [31:0] rd_req_lba
);
  AST_BUS_IMPLIES_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    bus_own |-> cpu_rst_hold); // R2
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_valid && !rd_req_ready) |=> (rd_req_valid && $stable(rd_req_lba))); // R3
  AST_LKP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    lkp_start |=> !lkp_start); // R8
  AST_CPY_UNDER_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    cpy_start |-> bus_own); // R9
  AST_DONE_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    status[4] |-> (!cpu_rst_hold && !bus_own)); // R9
  AST_FAIL_KEEPS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (|status[3:0]) |-> (cpu_rst_hold && !bus_own)); // R10
  AST_FAIL_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (|status[3:0]) |=> $stable(status)); // R10
  AST_STATUS_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(status)); // R12
endmodule

bind boot_seq_top boot_seq_checker u_chk (.*);

// File: tb/boot_seq_top_bench.sv
module boot_seq_top_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 6;
  // {sig, part, magic, root, lkp_err, cpy_err, stall, expected status}
  localparam logic [103:0] VEC [NV] = '{
    {16'hAA55, 32'h0000_0800, 16'h614E, 32'h0000_0003, 3'b000, 5'b10000},
    {16'h55AA, 32'h0000_0800, 16'h614E, 32'h0000_0003, 3'b000, 5'b00001},
    {16'hAA55, 32'h0000_0040, 16'h4E61, 32'h0000_0003, 3'b000, 5'b00010},
    {16'hAA55, 32'h0000_0100, 16'h614E, 32'h0000_0011, 3'b100, 5'b00100},
    {16'hAA55, 32'h0000_0200, 16'h614E, 32'h0000_0022, 3'b010, 5'b01000},
    {16'hAA55, 32'h1234_5678, 16'h614E, 32'hDEAD_BEEF, 3'b001, 5'b10000}};

  logic clk = 0, rst_n = 0, boot_start = 0;
  logic rd_req_ready = 0, rd_data_valid = 0;
  logic [7:0] rd_data = 0;
  logic lkp_done = 0, lkp_err = 0, cpy_done = 0, cpy_err = 0;
  logic rd_req_valid, rd_data_ready, lkp_start, cpy_start, cpu_rst_hold, bus_own;
  logic [31:0] rd_req_lba, lkp_root, part_base;
  logic [4:0] status;

  int tests = 0, fails = 0;
  int req_cnt = 0, lkp_cnt = 0, cpy_cnt = 0;
  logic [31:0] lba_first, lba_second, seen_root;
  logic hold_at_req, bus_at_req;
  logic [15:0] c_sig, c_magic;
  logic [31:0] c_part, c_root;
  logic c_lerr, c_cerr, c_stall;

  always #(CLK_PERIOD/2) clk = ~clk;

  boot_seq_top u_boot_seq_top (.*);

  task automatic chk(string req, logic ok, logic [63:0] act, logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] img(bit sb, int i);
    if (!sb) begin
      if (i == 'h1FE) return c_sig[7:0];
      if (i == 'h1FF) return c_sig[15:8];
      if (i >= 'h1C6 && i <= 'h1C9) return c_part[8*(i-'h1C6) +: 8];
    end else begin
      if (i == 0) return c_magic[7:0];
      if (i == 1) return c_magic[15:8];
      if (i >= 4 && i <= 7) return c_root[8*(i-4) +: 8];
    end
    return 8'(i) ^ 8'h5A;
  endfunction

  // storage reader model
  initial forever begin
    @(negedge clk);
    if (rd_req_valid) begin
      automatic bit sb = (req_cnt % 2) == 1;
      if (!sb) begin
        lba_first = rd_req_lba; hold_at_req = cpu_rst_hold; bus_at_req = bus_own;
      end else lba_second = rd_req_lba;
      req_cnt++;
      rd_req_ready = 1;
      @(negedge clk);
      rd_req_ready = 0;
      for (int i = 0; i < 512; i++) begin
        rd_data = img(sb, i);
        rd_data_valid = 1;
        while (!rd_data_ready) @(negedge clk);
        @(negedge clk);
        if (c_stall) begin
          rd_data_valid = 0;
          @(negedge clk);
        end
      end
      rd_data_valid = 0;
    end
  end

  // lookup engine model
  initial forever begin
    @(negedge clk);
    if (lkp_start) begin
      seen_root = lkp_root; lkp_cnt++;
      repeat (3) @(negedge clk);
      if (c_lerr) lkp_err = 1; else lkp_done = 1;
      @(negedge clk);
      lkp_err = 0; lkp_done = 0;
    end
  end

  // copy engine model
  initial forever begin
    @(negedge clk);
    if (cpy_start) begin
      cpy_cnt++;
      repeat (5) @(negedge clk);
      if (c_cerr) cpy_err = 1; else cpy_done = 1;
      @(negedge clk);
      cpy_err = 0; cpy_done = 0;
    end
  end

  task automatic do_reset();
    @(negedge clk); rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1; req_cnt = 0; lkp_cnt = 0; cpy_cnt = 0;
    @(negedge clk);
  endtask

  task automatic pulse_start();
    boot_start = 1; @(negedge clk); boot_start = 0;
  endtask

  task automatic wait_end();
    int n = 0;
    @(negedge clk);
    while (status == 0 && n < 5000) begin @(negedge clk); n++; end
  endtask

  task automatic load(int r);
    {c_sig, c_part, c_magic, c_root, c_lerr, c_cerr, c_stall} = VEC[r][103:5];
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    load(0);
    do_reset();
    // R1 reset state
    chk("R1 status", status == 0, status, 0);
    chk("R1 hold/bus/req", {cpu_rst_hold, bus_own, rd_req_valid} == 0,
        {cpu_rst_hold, bus_own, rd_req_valid}, 0);

    for (int r = 0; r < NV; r++) begin
      automatic logic [4:0] exp = VEC[r][4:0];
      automatic string rq = exp[0] ? "R4" : exp[1] ? "R6" : exp[2] ? "R8" : exp[3] ? "R9" : "R9 done";
      do_reset();
      load(r);
      pulse_start();
      wait_end();
      chk(rq, status == exp, status, exp);
      chk("R2 first request", lba_first == 0 && hold_at_req && bus_at_req,
          {hold_at_req, bus_at_req, lba_first}, {2'b11, 32'd0});
      chk("R3 request count", req_cnt == (exp[0] ? 1 : 2), req_cnt, exp[0] ? 1 : 2);
      chk("R9/R10 hold", cpu_rst_hold == !exp[4], cpu_rst_hold, !exp[4]);
      chk("R9/R10 bus", bus_own == 0, bus_own, 0);
      if (!exp[0]) begin
        chk("R5 part_base", part_base == c_part, part_base, c_part);
        chk("R5 superblock lba", lba_second == c_part, lba_second, c_part);
      end
      if (!exp[0] && !exp[1])
        chk("R7 root", seen_root == c_root && lkp_cnt == 1, seen_root, c_root);
      else
        chk("R8 no lookup", lkp_cnt == 0, lkp_cnt, 0);
      chk("R8 copy gating", cpy_cnt == ((exp[3] || exp[4]) ? 1 : 0), cpy_cnt,
          (exp[3] || exp[4]) ? 1 : 0);
    end

    // R10: start ignored after failure
    do_reset(); load(1);
    pulse_start(); wait_end();
    pulse_start();
    repeat (100) @(negedge clk);
    chk("R10 no new request", req_cnt == 1, req_cnt, 1);
    chk("R10 status kept", status == 5'b00001, status, 5'b00001);
    chk("R10 hold kept", cpu_rst_hold == 1, cpu_rst_hold, 1);

    // R11: start during boot ignored
    do_reset(); load(0);
    pulse_start();
    repeat (20) @(negedge clk);
    pulse_start();
    wait_end();
    chk("R11 busy start", req_cnt == 2 && lkp_cnt == 1 && status == 5'b10000,
        {req_cnt[7:0], lkp_cnt[7:0], 3'b0, status}, {8'd2, 8'd1, 8'b10000});

    // R11: rerun from done clears status
    pulse_start();
    chk("R11 status cleared", status == 0, status, 0);
    wait_end();
    chk("R11 rerun done", status == 5'b10000 && req_cnt == 4, status, 5'b10000);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule